// File: doc/BRIEF.md
# Integer ALU and Barrel Shifter

This is a purely combinational execution unit. It produces the register-write value for the arithmetic, logic and shift opcodes of a 32-bit load-store RISC core. It takes five inputs: the 5-bit opcode, the two register operands `b_val` and `c_val`, the 17-bit short constant from the instruction, and the low 5 bits of the modifier field.

`hit` reports whether the opcode belongs to this unit. When it does not, the result is forced to zero. The unit does not read the register file, write results back or produce flags. All arithmetic is 32-bit two's complement.

The shift count comes from the modifier bits when they are nonzero. When the modifier bits are zero, the count comes from the low 5 bits of `c_val`. Constants used by both the immediate add and the immediate logic ops are sign-extended from bit 16.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 12 gives `b_val + c_val` modulo 2^32 with `hit` high.
- R2: Opcode 13 gives `b_val` plus the 17-bit constant, where the constant is sign-extended from bit 16.
- R3: Opcode 14 gives `b_val - c_val` modulo 2^32.
- R4: Opcode 15 gives `-c_val`, the two's complement negation.
- R5: Opcode 20 gives `b_val & c_val`, opcode 22 gives `b_val | c_val`, and opcode 24 gives `~c_val`.
- R6: Opcode 21 ANDs `b_val` with the sign-extended constant, and opcode 23 ORs `b_val` with it.
- R7: The shift count is `mod_bits` when `mod_bits` is nonzero, and `c_val[4:0]` when `mod_bits` is zero.
- R8: Opcode 26 shifts `b_val` right by the count and fills the top with zeros.
- R9: Opcode 27 shifts `b_val` right by the count and fills the top with copies of bit 31.
- R10: Opcode 28 shifts `b_val` left by the count and fills the bottom with zeros.
- R11: Opcode 29 rotates `b_val` left by the count, so the bits that leave bit 31 re-enter at bit 0.
- R12: For opcodes 26 to 29, a count of zero returns `b_val` unchanged.
- R13: For any opcode outside 12..15, 20..24 and 26..29, `hit` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 5 | Operation code |
| b_val | input | 32 | First register operand |
| c_val | input | 32 | Second register operand; its low bits also serve as the fallback shift count |
| imm17 | input | 17 | Short signed constant |
| mod_bits | input | 5 | Low bits of the modifier field, used as the shift count when nonzero |
| result | output | 32 | Value to write to the register file |
| hit | output | 1 | High when the opcode is handled by this unit |

## Verification
The unit contains no registers, so each result is due in the same cycle as its operands. The bench applies a new operand set one time unit after a rising edge. It compares `result` and `hit` at the following falling edge, half a period later, when the combinational outputs have long settled. A behavioural reference computes each shift one bit at a time in a loop. The bench checks directed corner values first (constant sign bit, count taken from the modifier versus from the register, counts of 0 and 31, unused opcodes) and then a long run of random opcodes and operands.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int W    = 32,
  parameter int IMMW = 17,
  localparam int SHW = $clog2(W)
) (
  input  logic [4:0]     opcode,
  input  logic [W-1:0]   b_val,
  input  logic [W-1:0]   c_val,
  input  logic [IMMW-1:0] imm17,
  input  logic [SHW-1:0] mod_bits,
  output logic [W-1:0]   result,
  output logic           hit
);

  localparam logic [4:0] OP_ADD = 5'd12, OP_ADDI = 5'd13, OP_SUB = 5'd14, OP_NEG = 5'd15;
  localparam logic [4:0] OP_AND = 5'd20, OP_ANDI = 5'd21, OP_OR = 5'd22, OP_ORI = 5'd23;
  localparam logic [4:0] OP_NOT = 5'd24;
  localparam logic [4:0] OP_SHR = 5'd26, OP_SHRA = 5'd27, OP_SHL = 5'd28, OP_ROL = 5'd29;

  logic [W-1:0]   k_ext;
  logic [SHW-1:0] amt;
  logic [2*W-1:0] rot_wide;
  logic [W-1:0]   sra_val;

  assign k_ext    = {{(W-IMMW){imm17[IMMW-1]}}, imm17};
  assign amt      = (mod_bits != '0) ? mod_bits : c_val[SHW-1:0];
  assign rot_wide = {b_val, b_val} << amt;
  assign sra_val  = $unsigned($signed(b_val) >>> amt);

  always_comb begin
    hit    = 1'b1;
    result = '0;
    unique case (opcode)
      OP_ADD:  result = b_val + c_val;
      OP_ADDI: result = b_val + k_ext;
      OP_SUB:  result = b_val - c_val;
      OP_NEG:  result = '0 - c_val;
      OP_AND:  result = b_val & c_val;
      OP_ANDI: result = b_val & k_ext;
      OP_OR:   result = b_val | c_val;
      OP_ORI:  result = b_val | k_ext;
      OP_NOT:  result = ~c_val;
      OP_SHR:  result = b_val >> amt;
      OP_SHRA: result = sra_val;
      OP_SHL:  result = b_val << amt;
      OP_ROL:  result = rot_wide[2*W-1:W];
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({opcode, b_val, c_val, imm17, mod_bits})) begin
      if (opcode == OP_ADD)
        assert_add_inverse_R1: assert (result - c_val == b_val);
      if (opcode == OP_SUB)
        assert_sub_inverse_R3: assert (result + c_val == b_val);
      if (opcode == OP_NEG)
        assert_neg_sum_zero_R4: assert (result + c_val == '0);
      if (opcode == OP_NOT)
        assert_not_complement_R5: assert ((result ^ c_val) == '1);
      if (opcode == OP_ROL)
        assert_rol_keeps_ones_R11: assert ($countones(result) == $countones(b_val));
      if (opcode >= OP_SHR && opcode <= OP_ROL && mod_bits == '0 && c_val[SHW-1:0] == '0)
        assert_zero_count_passthru_R12: assert (result == b_val);
      if (!hit)
        assert_idle_zero_R13: assert (result == '0);
    end
  end

endmodule

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;
  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;

  logic [4:0]  opcode;
  logic [31:0] b_val, c_val;
  logic [16:0] imm17;
  logic [4:0]  mod_bits;
  logic [31:0] result;
  logic        hit;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int_exec_unit u_int_exec_unit (
    .opcode(opcode), .b_val(b_val), .c_val(c_val), .imm17(imm17),
    .mod_bits(mod_bits), .result(result), .hit(hit)
  );

  function automatic logic [32:0] ref_model(input logic [4:0] op, input logic [31:0] b,
      input logic [31:0] c, input logic [16:0] k, input logic [4:0] m);
    logic [31:0] kx, r;
    int n;
    logic ok;
    kx = 32'(signed'(k));
    n = (m != 0) ? int'(m) : int'(c[4:0]);
    ok = 1;
    r = 0;
    case (int'(op))
      12: r = b + c;
      13: r = b + kx;
      14: r = b - c;
      15: r = 0 - c;
      20: r = b & c;
      21: r = b & kx;
      22: r = b | c;
      23: r = b | kx;
      24: r = ~c;
      26: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? b[i+n] : 1'b0;
      27: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? b[i+n] : b[31];
      28: for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? b[i-n] : 1'b0;
      29: for (int i = 0; i < 32; i++) r[i] = b[(i - n + 32) % 32];
      default: begin ok = 0; r = 0; end
    endcase
    return {ok, r};
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (int'(op))
      12: return "R1"; 13: return "R2"; 14: return "R3"; 15: return "R4";
      20, 22, 24: return "R5"; 21, 23: return "R6";
      26: return "R8"; 27: return "R9"; 28: return "R10"; 29: return "R11";
      default: return "R13";
    endcase
  endfunction

  task automatic apply(input logic [4:0] op, input logic [31:0] b, input logic [31:0] c,
                       input logic [16:0] k, input logic [4:0] m, input string tag);
    logic [32:0] exp;
    @(posedge clk); #1;
    opcode = op; b_val = b; c_val = c; imm17 = k; mod_bits = m;
    exp = ref_model(op, b, c, k, m);
    @(negedge clk);
    checks++;
    if ({hit, result} !== exp) begin
      failures++;
      $display("FAIL %s op=%0d actual hit=%0b result=%h expected hit=%0b result=%h",
               tag, op, hit, result, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    opcode = 0; b_val = 32'hFFFF_FFFF; c_val = 32'h1234_5678; imm17 = 0; mod_bits = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (hit !== 1'b0 || result !== 32'h0) begin
      failures++;
      $display("FAIL R13 reset state actual hit=%0b result=%h expected hit=0 result=0", hit, result);
    end
    rst = 0;
    apply(12, 32'hFFFF_FFFF, 32'h2, 0, 0, "R1");
    apply(12, 32'h7FFF_FFFF, 32'h1, 0, 0, "R1");
    apply(13, 32'h100, 32'h0, 17'h1_FFFF, 0, "R2");
    apply(13, 32'h100, 32'h0, 17'h0_FFFF, 0, "R2");
    apply(14, 32'h0, 32'h1, 0, 0, "R3");
    apply(15, 32'h0, 32'h8000_0000, 0, 0, "R4");
    apply(15, 32'h0, 32'h5, 0, 0, "R4");
    apply(20, 32'hF0F0_F0F0, 32'hFF00_FF00, 0, 0, "R5");
    apply(22, 32'hF0F0_F0F0, 32'h0F00_0F00, 0, 0, "R5");
    apply(24, 32'h0, 32'hA5A5_0000, 0, 0, "R5");
    apply(21, 32'hDEAD_BEEF, 0, 17'h1_0F0F, 0, "R6");
    apply(23, 32'h0000_0001, 0, 17'h1_0000, 0, "R6");
    apply(23, 32'h0000_0001, 0, 17'h0_8000, 0, "R6");
    apply(26, 32'h8000_0000, 32'h0000_0003, 0, 5'd4, "R7");
    apply(26, 32'h8000_0000, 32'hFFFF_FFE3, 0, 5'd0, "R7");
    apply(26, 32'hF000_000F, 0, 0, 5'd31, "R8");
    apply(27, 32'h8000_0010, 0, 0, 5'd4, "R9");
    apply(27, 32'h4000_0010, 0, 0, 5'd31, "R9");
    apply(28, 32'h0000_0003, 0, 0, 5'd31, "R10");
    apply(29, 32'h8000_0001, 0, 0, 5'd1, "R11");
    apply(29, 32'h1234_5678, 32'h8, 0, 5'd0, "R11");
    for (int op = 26; op <= 29; op++) apply(5'(op), 32'hC3A5_0F96, 32'hFFFF_FFE0, 0, 0, "R12");
    apply(25, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 17'h1_FFFF, 5'd3, "R13");
    apply(31, 32'h1, 32'h1, 0, 0, "R13");
    apply(16, 32'h1, 32'h1, 0, 0, "R13");
    for (int i = 0; i < 2000; i++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 31));
      apply(op, $urandom, $urandom, 17'($urandom), ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom),
            tag_of(op));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule